// File: doc/BRIEF.md
# Runtime-Configurable Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. The frame shape comes from a setup word that software or neighbouring logic may rewrite at any time. That word sets the number of data bits (five to eight), one or two stop bits, the parity choice (none, odd, even, or a constant mark or space bit) and the bit period in system clocks.

A producer offers a byte with `inValid`. The block takes it on the first clock edge at which it is not busy. On that same edge it captures the setup word, so every frame keeps one shape from its start bit to its last stop bit. `busy` stays high for exactly one bit period per frame bit and then falls. A producer that keeps `inValid` high gets frames sent back to back, with a single idle clock between them.

Top module: `serial_tx_rt`

## Requirements
- R1: After reset and whenever `busy` is low, `txLine` is 1 and `busy` is 0.
- R2: A frame begins with a start bit of level 0. Every bit of the frame, the start bit included, lasts exactly `setupWord[23:0]` clocks; this divisor must be at least 2.
- R3: `setupWord[25:24]` sets the data length: 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Data bits go out least significant first, and the upper input bits beyond the length are ignored.
- R4: The frame ends with stop bits of level 1. When `setupWord[26]` is 1 there are two of them, otherwise one.
- R5: When `setupWord[27]` is 1 and `setupWord[28]` is 0, a parity bit follows the data bits. It gives odd parity over the sent data bits when `setupWord[29]` is 0 and even parity when it is 1.
- R6: When `setupWord[27]` and `setupWord[28]` are both 1, the parity bit equals `setupWord[29]` whatever the data.
- R7: When `setupWord[27]` is 0, the first stop bit follows the last data bit directly.
- R8: A byte is accepted on a rising edge where `inValid` is 1 and `busy` is 0. On that edge `busy` rises and `txLine` drops to start the frame. `busy` stays high for exactly (frame bits × divisor) clocks. `inValid` has no effect while `busy` is high.
- R9: The setup word is captured when a byte is accepted. Changing it during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupWord | input | 30 | Divisor [23:0], length code [25:24], two-stop [26], parity enable [27], fixed parity [28], parity type [29] |
| inValid | input | 1 | Byte offered |
| inData | input | 8 | Byte to send |
| busy | output | 1 | Frame in progress |
| txLine | output | 1 | Serial output, idles high |

## Verification
Two events can land on the same clock edge: the end of one frame and the acceptance of the next byte. The new byte may also arrive together with a new setup word. The bench holds `inValid` high across a frame boundary and changes the setup word and data while the first frame is still running. It then samples the middle of every bit, and it checks that `busy` falls on the expected clock, that the line idles for exactly one clock, and that each frame has the shape of its own setup word. Separate runs rewrite the setup word and pulse `inValid` during a frame to show that neither touches it.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int DIV_W  = 24;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int SETUP_W = DIV_W + 6;

  typedef struct packed {
    logic             parType;
    logic             parFix;
    logic             parEn;
    logic             stopTwo;
    logic [1:0]       lenCode;
    logic [DIV_W-1:0] baudDiv;
  } txCfg_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } txPhase_e;

  typedef struct packed {
    logic     load;
    logic     step;
    txPhase_e sel;
  } txStrobe_t;
endpackage

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  txCfg_t    cfgQ,
  output txStrobe_t strb,
  output logic      busy
);
  txPhase_e         state;
  logic [DIV_W-1:0] baudCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             stopIdx;
  logic             lastTick;
  logic [CNT_W-1:0] lastBit;

  assign lastTick = ({1'b0, baudCnt} + 1'b1) >= {1'b0, cfgQ.baudDiv};
  assign lastBit  = CNT_W'(DATA_W - 1) - CNT_W'(cfgQ.lenCode);
  assign busy     = (state != PH_IDLE);

  always_comb begin
    strb = '{load: 1'b0, step: 1'b0, sel: PH_IDLE};
    if (state == PH_IDLE) begin
      if (inValid) begin
        strb.load = 1'b1;
        strb.step = 1'b1;
        strb.sel  = PH_START;
      end
    end else if (lastTick) begin
      strb.step = 1'b1;
      case (state)
        PH_START: strb.sel = PH_DATA;
        PH_DATA: begin
          if (bitCnt == lastBit) strb.sel = cfgQ.parEn ? PH_PAR : PH_STOP;
          else                   strb.sel = PH_DATA;
        end
        PH_PAR:  strb.sel = PH_STOP;
        PH_STOP: strb.sel = (cfgQ.stopTwo && !stopIdx) ? PH_STOP : PH_IDLE;
        default: strb.sel = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
      stopIdx <= 1'b0;
    end else if (strb.step) begin
      state   <= strb.sel;
      baudCnt <= '0;
      stopIdx <= (state == PH_STOP) && (strb.sel == PH_STOP);
      if (state == PH_DATA && strb.sel == PH_DATA) bitCnt <= bitCnt + 1'b1;
      else                                         bitCnt <= '0;
    end else if (state != PH_IDLE) begin
      baudCnt <= baudCnt + 1'b1;
    end
  end

  // R3: the data bit index never passes the selected word length
  a_r3_bit_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_DATA) |-> (bitCnt <= lastBit));

  // R2: the bit timer stays inside one bit period
  a_r2_baud_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE && cfgQ.baudDiv > 1) |-> ({1'b0, baudCnt} < {1'b0, cfgQ.baudDiv}));
endmodule

// File: rtl/serial_tx_dpath.sv
module serial_tx_dpath
  import serial_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [SETUP_W-1:0] setupWord,
  input  logic [DATA_W-1:0] inData,
  output txCfg_t            cfgQ,
  output logic              txLine
);
  logic [DATA_W-1:0] shiftQ;
  logic              parAcc;
  logic              parBit;

  assign parBit = cfgQ.parFix ? cfgQ.parType : (cfgQ.parType ? parAcc : ~parAcc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      shiftQ <= '0;
      parAcc <= 1'b0;
      txLine <= 1'b1;
    end else begin
      if (strb.load) begin
        cfgQ   <= txCfg_t'(setupWord);
        shiftQ <= inData;
        parAcc <= 1'b0;
      end
      if (strb.step) begin
        case (strb.sel)
          PH_START: txLine <= 1'b0;
          PH_DATA: begin
            txLine <= shiftQ[0];
            shiftQ <= shiftQ >> 1;
            parAcc <= parAcc ^ shiftQ[0];
          end
          PH_PAR:  txLine <= parBit;
          default: txLine <= 1'b1;
        endcase
      end
    end
  end

  // R9: the captured setup only changes when a byte is loaded
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(cfgQ));

  // R4: a stop step always leaves the line high
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.sel == PH_STOP) |=> txLine);
endmodule

// File: rtl/serial_tx_rt.sv
module serial_tx_rt
  import serial_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SETUP_W-1:0] setupWord,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  output logic               busy,
  output logic               txLine
);
  txStrobe_t strb;
  txCfg_t    cfgQ;

  serial_tx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cfgQ(cfgQ),
    .strb(strb), .busy(busy)
  );

  serial_tx_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .setupWord(setupWord),
    .inData(inData), .cfgQ(cfgQ), .txLine(txLine)
  );

  // R1: idle line is high
  a_r1_idle_line: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R8: an accepted byte starts a frame on the same edge
  a_r8_accept_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && inValid) |=> (busy && !txLine));
endmodule

// File: tb/sim_serial_tx_rt.sv
module sim_serial_tx_rt;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [29:0] setupWord = '0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        busy;
  logic        txLine;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [11:0] bits;
    int          nBits;
    int          nData;
    int          hasPar;
    int          div;
    string       tag;
  } frame_t;

  frame_t expQ[$];

  always #5 clk = ~clk;

  serial_tx_rt u0 (
    .clk(clk), .rstN(rstN), .setupWord(setupWord), .inValid(inValid),
    .inData(inData), .busy(busy), .txLine(txLine)
  );

  function automatic logic [29:0] mkSetup(int div, int len, bit s, bit p, bit f, bit t);
    return {t, f, p, s, 2'(len), 24'(div)};
  endfunction

  task automatic check(bit ok, string what, logic act, logic exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual %b expected %b", what, act, exp);
    end
  endtask

  // expected frame from the requirements
  task automatic pushFrame(logic [7:0] d, logic [29:0] s, string tag);
    frame_t f;
    int n;
    logic x;
    n = 8 - int'(s[25:24]);
    f.bits = '0;
    f.nBits = 0;
    f.bits[f.nBits++] = 1'b0;
    x = 1'b0;
    for (int i = 0; i < n; i++) begin
      f.bits[f.nBits++] = d[i];
      x ^= d[i];
    end
    f.nData = n;
    f.hasPar = s[27];
    if (s[27]) f.bits[f.nBits++] = s[28] ? s[29] : (s[29] ? x : ~x);
    f.bits[f.nBits++] = 1'b1;
    if (s[26]) f.bits[f.nBits++] = 1'b1;
    f.div = int'(s[23:0]);
    f.tag = tag;
    expQ.push_back(f);
  endtask

  task automatic sendWord(logic [7:0] d, logic [29:0] s, string tag);
    pushFrame(d, s, tag);
    do @(negedge clk); while (busy);
    setupWord = s;
    inData = d;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (busy || expQ.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  // monitor: detect start, sample every bit mid-period, then check busy edge
  initial begin
    frame_t f;
    string role;
    forever begin
      @(negedge clk);
      if (rstN && !txLine) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected frame start", txLine, 1'b1);
        end else begin
          f = expQ.pop_front();
          for (int k = 0; k < f.nBits; k++) begin
            repeat ((k == 0) ? f.div / 2 : f.div) @(negedge clk);
            if (k == 0)                                   role = "R2 start";
            else if (k <= f.nData)                        role = "R3 data";
            else if (f.hasPar != 0 && k == f.nData + 1)   role = "R5/R6 parity";
            else if (f.hasPar == 0 && k == f.nData + 1)   role = "R7 stop after data";
            else                                          role = "R4 stop";
            check(txLine === f.bits[k], $sformatf("%s %s bit %0d", f.tag, role, k),
                  txLine, f.bits[k]);
          end
          repeat (f.div - f.div / 2 - 1) @(negedge clk);
          check(busy === 1'b1, $sformatf("%s R8 busy held to frame end", f.tag), busy, 1'b1);
          @(negedge clk);
          check(busy === 1'b0, $sformatf("%s R8 busy falls after last stop", f.tag), busy, 1'b0);
          check(txLine === 1'b1, $sformatf("%s R1 line idles high", f.tag), txLine, 1'b1);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual running expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R1 reset line", txLine, 1'b1);
    check(busy === 1'b0, "R1 reset busy", busy, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(txLine === 1'b1, "R1 idle after reset", txLine, 1'b1);

    sendWord(8'hA5, mkSetup(4, 0, 0, 0, 0, 0), "R7 8N1");
    waitDone();
    sendWord(8'hF3, mkSetup(5, 1, 0, 1, 0, 0), "R5 7O1");
    waitDone();
    sendWord(8'h2D, mkSetup(3, 2, 1, 1, 0, 1), "R5 6E2");
    waitDone();
    sendWord(8'hFF, mkSetup(4, 3, 0, 1, 1, 1), "R6 5M1");
    waitDone();
    sendWord(8'h81, mkSetup(6, 0, 0, 1, 1, 0), "R6 8S1");
    waitDone();
    sendWord(8'h00, mkSetup(7, 0, 1, 1, 0, 1), "R4 8E2");
    waitDone();
    sendWord(8'hE0, mkSetup(2, 3, 0, 0, 0, 0), "R3 5N1 upper ignored");
    waitDone();

    // R9: rewrite setup mid-frame; R8: pulse inValid while busy
    sendWord(8'h5A, mkSetup(5, 0, 1, 1, 0, 0), "R9 setup change");
    repeat (7) @(negedge clk);
    setupWord = mkSetup(3, 3, 0, 0, 0, 0);
    inData = 8'h11;
    inValid = 1'b1;
    repeat (4) @(negedge clk);
    inValid = 1'b0;
    waitDone();

    // back to back: next byte and setup arrive while the first frame runs
    pushFrame(8'h3C, mkSetup(4, 0, 0, 1, 0, 1), "R8 pair first");
    pushFrame(8'h17, mkSetup(3, 2, 1, 0, 0, 0), "R9 pair second");
    do @(negedge clk); while (busy);
    setupWord = mkSetup(4, 0, 0, 1, 0, 1);
    inData = 8'h3C;
    inValid = 1'b1;
    @(negedge clk);
    setupWord = mkSetup(3, 2, 1, 0, 0, 0);
    inData = 8'h17;
    do @(negedge clk); while (busy);
    @(negedge clk);
    inValid = 1'b0;
    waitDone();

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule